// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Unit

This block sits on the command side of a serial flash device. It keeps the status byte: a status-write lock bit, a three-bit protected-region selector, the write-enable latch and the busy flag. It also decides whether each decoded command may go ahead. The command decoder presents one operation per clock, with a byte address and a data byte. The unit answers with a one-cycle accept or reject pulse. An accepted write-status, program or erase starts a busy period whose length is a parameter per operation.

Independently of the command port, the unit watches the serial pins: select, serial clock and serial data in, all oversampled by the system clock. When the host shifts in the status-read opcode, the unit streams the status byte on the serial output for as long as select stays low. The byte is reloaded with live contents at every byte boundary. The output drive enable is low whenever select is high.

The array is 2^`ADDR_W` bytes. The region selector protects a power-of-two slice at the top of the array. The write-protect pin combined with the lock bit freezes the protection settings.

Top module: `flash_wp_status`

## Requirements
- R1: After reset the status byte is 8'h00, cmd_ok, cmd_rej and so_oe are 0.
- R2: Opcode encoding on cmd_op: 0 none, 1 write-enable, 2 status-write, 3 page-program, 4 sector-erase, 5 bulk-erase, 6 and 7 reserved. Every nonzero cmd_op gives exactly one of cmd_ok or cmd_rej in the next cycle. Reserved opcodes are rejected and change nothing. Write-enable is always accepted when idle and sets the latch.
- R3: Status byte layout is lock at bit 7, selector at bits 4..2, write-enable latch at bit 1 and busy at bit 0. Bits 6..5 read 0.
- R4: With the latch at 0, status-write, page-program, sector-erase and bulk-erase are rejected and leave the lock and selector unchanged.
- R5: An accepted status-write copies cmd_data bit 7 into the lock and cmd_data bits 4..2 into the selector. All other data bits are ignored.
- R6: While the lock is 1 and wp_n is 0, status-write is rejected and the lock and selector keep their values. With wp_n at 1, the lock does not block status-write.
- R7: Page-program and sector-erase are rejected when cmd_addr lies in the protected region. For selector value s from 1 to 5 the region is the addresses at or above 2^ADDR_W - 2^(ADDR_W-6+s). Values 6 and 7 protect the whole array. Value 0 protects nothing.
- R8: Bulk-erase is accepted only when the selector is 0.
- R9: An accepted status-write, program or erase holds busy at 1 for exactly WRSR_CYC, PP_CYC, SE_CYC or BE_CYC cycles, counted from the cycle after acceptance. Busy and the latch fall together.
- R10: A rejected status-write, program or erase clears the latch.
- R11: While busy is 1, every command is rejected and the status byte keeps its value.
- R12: With cs_n low, opcode 8'h05 shifted MSB first on si (sampled on rising sck) starts a status stream. Each falling sck drives the next bit on so, MSB first, with so_oe at 1. Any other opcode leaves so_oe at 0.
- R13: While cs_n stays low the status byte repeats, reloaded with live contents at each byte start. so_oe is 0 whenever cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Decoded operation |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | Status-write data byte |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_ok | output | 1 | Command accepted pulse |
| cmd_rej | output | 1 | Command rejected pulse |
| status | output | 8 | Current status byte |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output drive enable for so |

## Verification
On every cycle the assertions check the following: one result pulse per command, the gating by the write-enable latch, the freeze under hardware protection, the bulk-erase rule, the lockout while busy, and that the latch is clear when busy falls. The bench shows the rest. It sweeps every selector value against addresses on both sides of each region boundary. It measures the busy length of each operation. It shifts status streams over the serial pins, including one that spans the end of a busy period, so that the first and last bytes differ.

// File: rtl/flash_wp_status.sv
module flash_wp_status #(
  parameter int ADDR_W   = 21,
  parameter int WRSR_CYC = 5,
  parameter int PP_CYC   = 12,
  parameter int SE_CYC   = 40,
  parameter int BE_CYC   = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  output logic              cmd_ok,
  output logic              cmd_rej,
  output logic [7:0]        status,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_oe
);
  localparam logic [2:0] OP_WREN = 3'd1, OP_WRSR = 3'd2, OP_PP = 3'd3,
                         OP_SE = 3'd4, OP_BE = 3'd5;
  localparam int MAXC = (BE_CYC > SE_CYC ? BE_CYC : SE_CYC) > (PP_CYC > WRSR_CYC ? PP_CYC : WRSR_CYC)
                      ? (BE_CYC > SE_CYC ? BE_CYC : SE_CYC) : (PP_CYC > WRSR_CYC ? PP_CYC : WRSR_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [7:0] RD_OPC = 8'h05;

  logic          lock, wel, wip;
  logic [2:0]    sel;
  logic [CW-1:0] cnt;

  assign status = {lock, 2'b00, sel, wel, wip};

  wire hw_prot  = lock & ~wp_n;
  wire modify   = (cmd_op == OP_WRSR) | (cmd_op == OP_PP) | (cmd_op == OP_SE) | (cmd_op == OP_BE);
  wire cmd_live = cmd_valid & (cmd_op != 3'd0);

  logic in_prot;
  always_comb begin
    in_prot = 1'b0;
    if (sel >= 3'd6) in_prot = 1'b1;
    else if (sel != 3'd0) begin
      in_prot = 1'b1;
      for (int i = 0; i < 6; i++)
        if (i < 6 - int'(sel) && !cmd_addr[ADDR_W-1-i]) in_prot = 1'b0;
    end
  end

  logic          allow;
  logic [CW-1:0] load;
  always_comb begin
    allow = 1'b0;
    load  = '0;
    case (cmd_op)
      OP_WREN: allow = 1'b1;
      OP_WRSR: begin allow = wel & ~hw_prot;      load = CW'(WRSR_CYC - 1); end
      OP_PP:   begin allow = wel & ~in_prot;      load = CW'(PP_CYC - 1);   end
      OP_SE:   begin allow = wel & ~in_prot;      load = CW'(SE_CYC - 1);   end
      OP_BE:   begin allow = wel & (sel == 3'd0); load = CW'(BE_CYC - 1);   end
      default: allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0; sel <= '0; wel <= 1'b0; wip <= 1'b0; cnt <= '0;
      cmd_ok <= 1'b0; cmd_rej <= 1'b0;
    end else begin
      cmd_ok  <= 1'b0;
      cmd_rej <= 1'b0;
      if (wip) begin
        if (cnt == '0) begin wip <= 1'b0; wel <= 1'b0; end
        else cnt <= cnt - 1'b1;
      end
      if (cmd_live) begin
        if (wip || !allow) begin
          cmd_rej <= 1'b1;
          if (!wip && modify) wel <= 1'b0;
        end else begin
          cmd_ok <= 1'b1;
          if (cmd_op == OP_WREN) wel <= 1'b1;
          else begin
            wip <= 1'b1;
            cnt <= load;
            if (cmd_op == OP_WRSR) begin
              lock <= cmd_data[7];
              sel  <= cmd_data[4:2];
            end
          end
        end
      end
    end
  end

  logic       sck_q, rd_mode, rd_act, op_done;
  logic [2:0] in_cnt, out_cnt;
  logic [6:0] in_sr;
  logic [7:0] out_sr;
  wire sck_rise = sck & ~sck_q;
  wire sck_fall = ~sck & sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; rd_mode <= 1'b0; rd_act <= 1'b0; op_done <= 1'b0;
      in_cnt <= '0; out_cnt <= '0; in_sr <= '0; out_sr <= '0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        rd_mode <= 1'b0; rd_act <= 1'b0; op_done <= 1'b0;
        in_cnt <= '0; out_cnt <= '0;
      end else begin
        if (sck_rise && !op_done) begin
          in_sr  <= {in_sr[5:0], si};
          in_cnt <= in_cnt + 1'b1;
          if (in_cnt == 3'd7) begin
            op_done <= 1'b1;
            rd_mode <= ({in_sr, si} == RD_OPC);
          end
        end
        if (sck_fall && rd_mode) begin
          rd_act  <= 1'b1;
          out_sr  <= (out_cnt == 3'd0) ? status : {out_sr[6:0], 1'b0};
          out_cnt <= out_cnt + 1'b1;
        end
      end
    end
  end

  assign so_oe = ~cs_n & rd_act;
  assign so    = so_oe & out_sr[7];

  p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_live |=> (cmd_ok ^ cmd_rej));
  p_no_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_live |=> !(cmd_ok | cmd_rej));
  p_wel_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && modify && !wel) |=> (!cmd_ok && $stable(lock) && $stable(sel)));
  p_hw_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !wp_n) |=> ($stable(lock) && $stable(sel)));
  p_bulk_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_BE && sel != 3'd0) |=> !cmd_ok);
  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
  p_busy_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_live && wip) |=> (cmd_rej && $stable(lock) && $stable(sel)));
  p_oe_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so_oe);
endmodule

// File: tb/tb_flash_wp_status.sv
`timescale 1ns/1ps
module tb_flash_wp_status;
  localparam int AW = 21;
  localparam int C_WRSR = 5, C_PP = 12, C_SE = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, wp_n = 1'b1, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic cmd_ok, cmd_rej, so, so_oe;
  logic [7:0] status;
  int n_chk = 0, n_fail = 0;
  logic [7:0] rd [4];
  logic oe_seen;

  always #2.5 clk = ~clk;

  flash_wp_status dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n), .cmd_ok(cmd_ok), .cmd_rej(cmd_rej),
    .status(status), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       output logic ok);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
    ok = cmd_ok;
    if ((cmd_ok ^ cmd_rej) !== 1'b1) chk("R2 single result", {cmd_ok, cmd_rej}, 2'b01);
  endtask

  task automatic wait_idle();
    while (status[0]) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (status[0]) begin n++; @(negedge clk); end
  endtask

  task automatic spi(input logic [7:0] opc, input int nb);
    oe_seen = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      si = opc[7-i];
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    for (int b = 0; b < nb; b++)
      for (int i = 0; i < 8; i++) begin
        repeat (4) @(negedge clk);
        oe_seen = oe_seen | so_oe;
        rd[b][7-i] = so;
        sck = 1'b1;
        repeat (4) @(negedge clk); sck = 1'b0;
      end
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R13 oe off with cs high", so_oe, 1'b0);
  endtask

  function automatic logic prot(input int s, input int a);
    if (s == 0) return 1'b0;
    if (s >= 6) return 1'b1;
    return a >= (1 << AW) - (1 << (AW - 6 + s));
  endfunction

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ok;
    int n;
    int addrs [4];
    repeat (3) @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 results", {cmd_ok, cmd_rej}, 2'b00);
    chk("R1 oe", so_oe, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(3'd3, '0, 8'h00, ok);
    chk("R4 program without latch", ok, 1'b0);
    issue(3'd2, '0, 8'h9C, ok);
    chk("R4 status-write without latch", ok, 1'b0);
    chk("R4 status unchanged", status, 8'h00);

    issue(3'd1, '0, 8'h00, ok);
    chk("R2 write-enable accepted", ok, 1'b1);
    chk("R3 latch at bit 1", status, 8'h02);
    issue(3'd6, '0, 8'hFF, ok);
    chk("R2 reserved rejected", ok, 1'b0);
    chk("R2 reserved no change", status, 8'h02);

    issue(3'd2, '0, 8'hFF, ok);
    chk("R5 status-write accepted", ok, 1'b1);
    busy_len(n);
    chk("R9 status-write busy length", n, C_WRSR);
    chk("R5 stored bits only", status, 8'h9C);

    wp_n = 1'b0;
    issue(3'd1, '0, 8'h00, ok);
    issue(3'd2, '0, 8'h00, ok);
    chk("R6 frozen write rejected", ok, 1'b0);
    chk("R6 R10 bits kept, latch cleared", status, 8'h9C);
    wp_n = 1'b1;
    issue(3'd1, '0, 8'h00, ok);
    issue(3'd2, '0, 8'h00, ok);
    chk("R6 write with pin high", ok, 1'b1);
    chk("R3 busy and latch bits", status, 8'h03);
    wait_idle();
    chk("R9 latch falls with busy", status, 8'h00);

    for (int s = 0; s < 8; s++) begin
      issue(3'd1, '0, 8'h00, ok);
      issue(3'd2, '0, 8'(s << 2), ok);
      wait_idle();
      chk("R5 selector", status, 8'(s << 2));
      addrs[0] = 0;
      addrs[1] = (1 << AW) - 1;
      addrs[2] = (1 << AW) - (1 << (AW - 6 + (s >= 1 && s <= 5 ? s : 1))) - 1;
      addrs[3] = addrs[2] + 1;
      for (int k = 0; k < 4; k++)
        for (int op = 3; op <= 4; op++) begin
          issue(3'd1, '0, 8'h00, ok);
          issue(3'(op), AW'(addrs[k]), 8'h00, ok);
          chk("R7 region decision", ok, !prot(s, addrs[k]));
          if (ok) begin
            busy_len(n);
            chk("R9 busy length", n, op == 3 ? C_PP : C_SE);
          end else chk("R10 latch cleared", status[1], 1'b0);
        end
      issue(3'd1, '0, 8'h00, ok);
      issue(3'd5, '0, 8'h00, ok);
      chk("R8 bulk erase", ok, s == 0);
      if (ok) wait_idle();
    end

    issue(3'd1, '0, 8'h00, ok);
    issue(3'd2, '0, 8'h14, ok);
    wait_idle();
    spi(8'h05, 2);
    chk("R12 oe driven", oe_seen, 1'b1);
    chk("R12 first byte", rd[0], 8'h14);
    chk("R13 repeat byte", rd[1], 8'h14);
    spi(8'h9F, 1);
    chk("R12 other opcode no drive", oe_seen, 1'b0);

    issue(3'd1, '0, 8'h00, ok);
    issue(3'd4, '0, 8'h00, ok);
    issue(3'd1, '0, 8'h00, ok);
    chk("R11 command while busy", ok, 1'b0);
    issue(3'd2, '0, 8'h80, ok);
    chk("R11 status kept", status, 8'h17);
    wait_idle();

    issue(3'd2, '0, 8'h00, ok);
    issue(3'd1, '0, 8'h00, ok);
    issue(3'd2, '0, 8'h00, ok);
    wait_idle();
    issue(3'd1, '0, 8'h00, ok);
    issue(3'd5, '0, 8'h00, ok);
    chk("R8 bulk erase with clear selector", ok, 1'b1);
    spi(8'h05, 4);
    chk("R12 busy read", rd[0], 8'h03);
    chk("R13 live after busy", rd[3], 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule